// File: doc/BRIEF.md
# Registered four-bit arithmetic unit

This block performs one of eight arithmetic operations on two unsigned operands (four bits wide by default). Each cycle it registers a two-bit select code, a carry-in, operands A and B and a valid flag. A single adder works on the registered values. Its second input is chosen by the select code, and the carry-in feeds the adder's carry. An optional chain of pipeline registers follows the adder. The result and its carry-out land in an output register that loads only when a valid item arrives.

The select code and carry-in together pick the operation. Code 0 passes A through, or increments it when carry-in is 1. Code 1 adds B, with the carry-in added as well. Code 2 adds the one's complement of B, so a carry-in of 1 yields A minus B. Code 3 adds all ones, so a carry-in of 0 yields A minus 1 and a carry-in of 1 yields A unchanged. The carry-out is always the adder's top bit.

The data path is a stream with a valid flag only and no ready. The unit never stalls, so the consumer must take every item in the cycle that `out_vld` is high. Items leave in the order they entered.

Top module: `arith4_reg`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `out_vld`, `out_f` and `out_cout` to zero, and it discards every item in flight. No item presented before the reset appears at the output afterwards.
- R2: An item presented with `in_vld` high before rising edge k appears with `out_vld` high after edge k+1+PIPE_STAGES. `out_vld` is low after the edge before that one, provided no other item was in flight.
- R3: With `in_sel`=0 (binary 00), {`out_cout`,`out_f`} equals A plus carry-in. Carry-in 0 gives F=A with carry 0. Carry-in 1 gives F=A+1, and A=15 gives F=0 with carry 1.
- R4: With `in_sel`=1 (binary 01), {`out_cout`,`out_f`} equals A+B+carry-in, taken as a five-bit sum.
- R5: With `in_sel`=2 (binary 10), {`out_cout`,`out_f`} equals A + (15−B) + carry-in. With carry-in 1 this is A−B modulo 16, with a carry of 1 exactly when A≥B.
- R6: With `in_sel`=3 (binary 11), {`out_cout`,`out_f`} equals A+15+carry-in. Carry-in 0 gives F=A−1 modulo 16, with a carry of 1 exactly when A is nonzero. Carry-in 1 gives F=A with a carry of 1.
- R7: A cycle with `in_vld` low produces no output. When `out_vld` is low, `out_f` and `out_cout` keep their previous values, whatever the operand, select and carry inputs do.
- R8: Items presented on consecutive cycles each come out on consecutive cycles, in the same order and with the correct results. This holds for all 2048 combinations of the eleven data and control inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input item valid |
| in_sel | input | 2 | Operation select; bit 1 is the upper select bit |
| in_cin | input | 1 | Carry-in |
| in_a | input | W | Operand A |
| in_b | input | W | Operand B |
| out_vld | output | 1 | Result valid; no back-pressure |
| out_f | output | W | Result |
| out_cout | output | 1 | Carry-out, the adder's top bit |

## Verification
Two events can fall in the same cycle here. One is a reset edge that arrives while valid items sit in the input, pipeline and output registers. The other is a new item being captured on the same edge that an earlier item loads the output. The bench provokes the first by asserting reset in the middle of a dense stream. It then checks that all outputs read zero and that no pre-reset item emerges later. It provokes the second by streaming every input combination back to back and matching each output cycle to the item expected at that position.

// File: rtl/arith4_pkg.sv
package arith4_pkg;
  localparam int DEF_W     = 4;
  localparam int DEF_STAGE = 1;

  // second adder operand picked by the select code
  typedef enum logic [1:0] {
    SEL_ZERO  = 2'd0,
    SEL_B     = 2'd1,
    SEL_NOT_B = 2'd2,
    SEL_ONES  = 2'd3
  } sel_e;
endpackage

// File: rtl/arith4_inreg.sv
module arith4_inreg #(
  parameter int W = arith4_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_vld,
  input  logic [1:0]   d_sel,
  input  logic         d_cin,
  input  logic [W-1:0] d_a,
  input  logic [W-1:0] d_b,
  output logic         q_vld,
  output logic [1:0]   q_sel,
  output logic         q_cin,
  output logic [W-1:0] q_a,
  output logic [W-1:0] q_b
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld <= 1'b0;
      q_sel <= '0;
      q_cin <= 1'b0;
      q_a   <= '0;
      q_b   <= '0;
    end else begin
      q_vld <= d_vld;
      q_sel <= d_sel;
      q_cin <= d_cin;
      q_a   <= d_a;
      q_b   <= d_b;
    end
  end
endmodule

// File: rtl/arith4_core.sv
module arith4_core #(
  parameter int W = arith4_pkg::DEF_W
) (
  input  logic [1:0]   sel,
  input  logic         cin,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W:0]   sum
);
  import arith4_pkg::*;

  logic [W-1:0] opb;

  always_comb begin
    unique case (sel_e'(sel))
      SEL_ZERO:  opb = '0;
      SEL_B:     opb = b;
      SEL_NOT_B: opb = ~b;
      default:   opb = '1;
    endcase
  end

  assign sum = {1'b0, a} + {1'b0, opb} + {{W{1'b0}}, cin};
endmodule

// File: rtl/arith4_stage.sv
module arith4_stage #(
  parameter int W     = arith4_pkg::DEF_W,
  parameter int DEPTH = arith4_pkg::DEF_STAGE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_vld,
  input  logic [W:0]   d_sum,
  output logic         q_vld,
  output logic [W:0]   q_sum
);
  localparam int SW = W + 2;

  generate
    if (DEPTH == 0) begin : g_bypass
      assign q_vld = d_vld;
      assign q_sum = d_sum;
    end else begin : g_pipe
      logic [SW-1:0] st [DEPTH];
      for (genvar k = 0; k < DEPTH; k++) begin : g_st
        always_ff @(posedge clk) begin
          if (rst) st[k] <= '0;
          else if (k == 0) st[k] <= {d_vld, d_sum};
          else st[k] <= st[(k == 0) ? 0 : k-1];
        end
      end
      assign q_vld = st[DEPTH-1][SW-1];
      assign q_sum = st[DEPTH-1][W:0];
    end
  endgenerate
endmodule

// File: rtl/arith4_outreg.sv
module arith4_outreg #(
  parameter int W = arith4_pkg::DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_vld,
  input  logic [W:0]   d_sum,
  output logic         q_vld,
  output logic [W-1:0] q_f,
  output logic         q_cout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld  <= 1'b0;
      q_f    <= '0;
      q_cout <= 1'b0;
    end else begin
      q_vld <= d_vld;
      if (d_vld) {q_cout, q_f} <= d_sum;
    end
  end
endmodule

// File: rtl/arith4_reg.sv
module arith4_reg #(
  parameter int W           = arith4_pkg::DEF_W,
  parameter int PIPE_STAGES = arith4_pkg::DEF_STAGE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_vld,
  input  logic [1:0]   in_sel,
  input  logic         in_cin,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_vld,
  output logic [W-1:0] out_f,
  output logic         out_cout
);
  logic         r_vld, r_cin;
  logic [1:0]   r_sel;
  logic [W-1:0] r_a, r_b;
  logic [W:0]   c_sum, p_sum;
  logic         p_vld;

  arith4_inreg #(.W(W)) u_in (
    .clk(clk), .rst(rst),
    .d_vld(in_vld), .d_sel(in_sel), .d_cin(in_cin), .d_a(in_a), .d_b(in_b),
    .q_vld(r_vld), .q_sel(r_sel), .q_cin(r_cin), .q_a(r_a), .q_b(r_b)
  );

  arith4_core #(.W(W)) u_core (
    .sel(r_sel), .cin(r_cin), .a(r_a), .b(r_b), .sum(c_sum)
  );

  arith4_stage #(.W(W), .DEPTH(PIPE_STAGES)) u_pipe (
    .clk(clk), .rst(rst),
    .d_vld(r_vld), .d_sum(c_sum),
    .q_vld(p_vld), .q_sum(p_sum)
  );

  arith4_outreg #(.W(W)) u_out (
    .clk(clk), .rst(rst),
    .d_vld(p_vld), .d_sum(p_sum),
    .q_vld(out_vld), .q_f(out_f), .q_cout(out_cout)
  );
endmodule

// File: rtl/arith4_chk.sv
module arith4_chk #(
  parameter int W = 4,
  parameter int P = 1
) (
  input logic         clk,
  input logic         rst,
  input logic         in_vld,
  input logic [1:0]   in_sel,
  input logic         in_cin,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_vld,
  input logic [W-1:0] out_f,
  input logic         out_cout
);
  localparam int LAT = P + 2;
  localparam logic [W:0] FULL = {1'b0, {W{1'b1}}};

  typedef struct packed {
    logic         v;
    logic [1:0]   op;
    logic         ci;
    logic [W-1:0] a;
    logic [W:0]   x;
  } ln_t;

  ln_t ln [LAT];
  logic [W:0] want;
  logic [W:0] ea, eb, ec;

  always_comb begin
    ea = {1'b0, in_a};
    eb = {1'b0, in_b};
    ec = {{W{1'b0}}, in_cin};
    case (in_sel)
      2'd0:    want = ea + ec;
      2'd1:    want = ea + eb + ec;
      2'd2:    want = ea + (FULL - eb) + ec;
      default: want = ea + FULL + ec;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) ln[k] <= '0;
    end else begin
      ln[0] <= '{v: in_vld, op: in_sel, ci: in_cin, a: in_a, x: want};
      for (int k = 1; k < LAT; k++) ln[k] <= ln[k-1];
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!out_vld && out_f == '0 && !out_cout));

  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    out_vld == ln[LAT-1].v);

  // R3 R4 R5 R6: value per select code
  a_r4_result: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> {out_cout, out_f} == ln[LAT-1].x);

  a_r6_dec_carry: assert property (@(posedge clk) disable iff (rst)
    (out_vld && ln[LAT-1].op == 2'd3 && !ln[LAT-1].ci) |-> (out_cout == (ln[LAT-1].a != '0)));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!out_vld && !$past(rst)) |-> ($stable(out_f) && $stable(out_cout)));
endmodule

bind arith4_reg arith4_chk #(.W(W), .P(PIPE_STAGES)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_sel(in_sel), .in_cin(in_cin),
  .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out_f(out_f), .out_cout(out_cout)
);

// File: tb/arith4_reg_bench.sv
`timescale 1ns/1ps
module arith4_reg_bench;
  localparam int W  = 4;
  localparam int PS = 1;
  localparam int LAT = PS + 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_vld = 1'b0;
  logic [1:0]   in_sel = '0;
  logic         in_cin = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         out_vld;
  logic [W-1:0] out_f;
  logic         out_cout;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  arith4_reg #(.W(W), .PIPE_STAGES(PS)) u_arith4_reg (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_sel(in_sel), .in_cin(in_cin),
    .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out_f(out_f), .out_cout(out_cout)
  );

  function automatic logic [W:0] model(input logic [1:0] s, input logic c,
                                       input logic [W-1:0] a, input logic [W-1:0] b);
    int r;
    case (s)
      2'd0:    r = int'(a) + int'(c);
      2'd1:    r = int'(a) + int'(b) + int'(c);
      2'd2:    r = int'(a) + (15 - int'(b)) + int'(c);
      default: r = int'(a) + 15 + int'(c);
    endcase
    return r[W:0];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] s, input logic c,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    in_vld = v; in_sel = s; in_cin = c; in_a = a; in_b = b;
  endtask

  // R1: state held in reset
  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 vld", out_vld, 0);
    chk("R1 f", out_f, 0);
    chk("R1 cout", out_cout, 0);
    rst = 1'b0;
  endtask

  // R2 latency plus value check for one operation
  task automatic t_one(input string req, input logic [1:0] s, input logic c,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] e;
    e = model(s, c, a, b);
    @(negedge clk);
    drive(1'b1, s, c, a, b);
    @(posedge clk);
    @(negedge clk);
    drive(1'b0, 2'd3, 1'b1, 4'hA, 4'h5);
    repeat (PS) begin @(posedge clk); @(negedge clk); end
    chk("R2 early", out_vld, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R2 vld", out_vld, 1);
    chk(req, {out_cout, out_f}, e);
    @(posedge clk);
    @(negedge clk);
    chk("R7 single", out_vld, 0);
  endtask

  // R7: idle cycles with changing inputs leave outputs alone
  task automatic t_hold;
    logic [W:0] keep;
    keep = {out_cout, out_f};
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, 2'(i), 1'(i), 4'(i * 3 + 1), 4'(15 - i));
      @(posedge clk);
      @(negedge clk);
      chk("R7 vld", out_vld, 0);
      chk("R7 data", {out_cout, out_f}, keep);
    end
  endtask

  // R8: every combination back to back
  task automatic t_stream;
    logic [W:0] e;
    int k;
    for (int j = 0; j < 2048 + LAT; j++) begin
      @(negedge clk);
      if (j >= LAT) begin
        k = j - LAT;
        e = model(2'(k >> 9), 1'(k >> 8), 4'(k >> 4), 4'(k));
        chk("R8 vld", out_vld, 1);
        chk("R8 data", {out_cout, out_f}, e);
      end else begin
        chk("R8 gap", out_vld, 0);
      end
      if (j < 2048) drive(1'b1, 2'(j >> 9), 1'(j >> 8), 4'(j >> 4), 4'(j));
      else drive(1'b0, 2'd0, 1'b0, 4'd0, 4'd0);
    end
    @(negedge clk);
    chk("R8 tail", out_vld, 0);
  endtask

  // R1: reset hits a full pipeline
  task automatic t_reset_mid;
    for (int j = 0; j < LAT + 1; j++) begin
      @(negedge clk);
      drive(1'b1, 2'd1, 1'b1, 4'(j + 3), 4'd7);
    end
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(1'b0, 2'd0, 1'b0, 4'd0, 4'd0);
    chk("R1 mid vld", out_vld, 0);
    chk("R1 mid data", {out_cout, out_f}, 0);
    rst = 1'b0;
    for (int j = 0; j < LAT + 2; j++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R1 no leak", out_vld, 0);
      chk("R1 no leak data", {out_cout, out_f}, 0);
    end
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_one("R3 pass", 2'd0, 1'b0, 4'd9, 4'd3);
    t_one("R3 inc wrap", 2'd0, 1'b1, 4'd15, 4'd0);
    t_one("R4 add", 2'd1, 1'b0, 4'd7, 4'd8);
    t_one("R4 add carry", 2'd1, 1'b1, 4'd15, 4'd15);
    t_one("R5 sub a<b", 2'd2, 1'b1, 4'd5, 4'd9);
    t_one("R5 sub a>b", 2'd2, 1'b1, 4'd9, 4'd5);
    t_one("R5 add notb", 2'd2, 1'b0, 4'd3, 4'd3);
    t_one("R6 dec zero", 2'd3, 1'b0, 4'd0, 4'd2);
    t_one("R6 dec", 2'd3, 1'b0, 4'd6, 4'd1);
    t_one("R6 pass", 2'd3, 1'b1, 4'd6, 4'd1);
    t_hold();
    t_stream();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule